// File: doc/BRIEF.md
# CAN Acceptance Filter Array

This block decides whether an incoming CAN frame is wanted, and by which message object. It keeps a bank of 64 message objects. Each object holds a 29-bit identifier, a 29-bit per-bit mask, an expected IDE (extended) flag, an expected direction, a use-mask enable, an IDE mask bit, a direction mask bit and a valid bit. When a frame's identifier, IDE flag and direction arrive with a strobe, every valid object compares them against its own settings in parallel. On the next clock edge the block reports whether any object accepted the frame and gives the number of the lowest-numbered object that did.

Objects are numbered 1 to 64. The number 0 means that no object accepted the frame. Software-side logic loads one object per cycle through a flat write port: a select value of k writes object k+1. A standard frame supplies its 11-bit identifier right-justified on the frame identifier input. The block moves that value to bits [28:18] before it compares, so a stored standard identifier is kept in bits [28:18] with bits [17:0] zero.

Top module: `can_accept_filter`

## Requirements
- R1: After synchronous reset all objects are invalid and res_vld, hit and hit_num are 0, so a frame presented right after reset is not accepted.
- R2: A frame strobed on frm_vld at one rising edge gives res_vld=1 with its hit and hit_num after that same edge. In cycles without a strobe, res_vld is 0 and hit and hit_num keep their last values.
- R3: An object whose valid bit is 0 never accepts a frame, even when all its other fields match.
- R4: When an object's use-mask bit is 0, its identifier mask, IDE mask and direction mask are ignored. All 29 identifier bits, the IDE flag and the direction must then equal the stored values.
- R5: When use-mask is 1, an identifier mask bit of 1 requires the aligned frame bit to equal the stored bit, and a mask bit of 0 makes that bit a don't-care.
- R6: When use-mask is 1, the IDE mask bit set to 1 requires frm_xtd to equal the stored IDE flag. Set to 0, the IDE flag is not compared.
- R7: When use-mask is 1, the direction mask bit set to 1 requires frm_dir to equal the stored direction. Set to 0, direction is not compared.
- R8: For a frame with frm_xtd=0, only frm_id[10:0] is used. It is compared as bits [28:18] of the identifier, and bits [17:0] are taken as 0. For frm_xtd=1, frm_id[28:0] is used as given.
- R9: When several objects accept a frame, hit_num is the lowest accepting object number (1 to 64). When none accepts, hit=0 and hit_num=0.
- R10: A write with cfg_we=1 and cfg_sel=k replaces all fields of object k+1 at that edge. A frame strobed in the same cycle is judged against the contents before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for one object |
| cfg_sel | input | 6 | Object select, value k addresses object k+1 |
| cfg_id | input | 29 | Stored identifier (standard form in bits [28:18]) |
| cfg_mask | input | 29 | Per-bit identifier mask, 1 = must match |
| cfg_xtd | input | 1 | Expected IDE flag |
| cfg_dir | input | 1 | Expected direction |
| cfg_use_mask | input | 1 | Enable the three mask fields |
| cfg_mask_xtd | input | 1 | Include IDE flag in compare |
| cfg_mask_dir | input | 1 | Include direction in compare |
| cfg_valid | input | 1 | Object takes part in filtering |
| frm_vld | input | 1 | Frame strobe |
| frm_id | input | 29 | Frame identifier (standard: bits [10:0]) |
| frm_xtd | input | 1 | Frame IDE flag |
| frm_dir | input | 1 | Frame direction |
| res_vld | output | 1 | Result valid, one cycle per strobe |
| hit | output | 1 | Some object accepted the frame |
| hit_num | output | 7 | Lowest accepting object number, 0 if none |

## Verification
Every result is due one edge after its strobe. Object writes take effect for strobes in the cycle after the write edge. The reference model in the bench updates its expected outputs and its object table at each rising edge from the inputs sampled there. Two nanoseconds after each edge the outputs are compared with the model, which lines up with the single register stage of the design. Test phases cover exact compare, per-bit masking, IDE and direction masking, standard alignment, invalid objects, priority among several matches and a write that coincides with a strobe.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic [ID_W-1:0] mask;
        logic            xtd;
        logic            dir;
        logic            use_mask;
        logic            mask_xtd;
        logic            mask_dir;
        logic            valid;
    } obj_cfg_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            xtd;
        logic            dir;
    } frame_t;

    // Standard identifiers sit in the top eleven bits for comparison.
    function automatic logic [ID_W-1:0] align_id(input logic [ID_W-1:0] raw,
                                                 input logic xtd);
        if (xtd)
            return raw;
        return {raw[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
    endfunction

    function automatic logic obj_accepts(input obj_cfg_t o, input frame_t f);
        logic [ID_W-1:0] care;
        logic            care_x;
        logic            care_d;
        care   = o.use_mask ? o.mask     : '1;
        care_x = o.use_mask ? o.mask_xtd : 1'b1;
        care_d = o.use_mask ? o.mask_dir : 1'b1;
        return o.valid
            && (((align_id(f.id, f.xtd) ^ o.id) & care) == '0)
            && (!care_x || (f.xtd == o.xtd))
            && (!care_d || (f.dir == o.dir));
    endfunction

endpackage

// File: rtl/can_flt_obj_store.sv
module can_flt_obj_store
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 64,
    localparam int SEL_W  = $clog2(NUM_OBJ)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  obj_cfg_t                   wdata,
    output obj_cfg_t [NUM_OBJ-1:0]     objs
);

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        always_ff @(posedge clk) begin
            if (rst)
                objs[g] <= '0;
            else if (we && (sel == SEL_W'(g)))
                objs[g] <= wdata;
        end
    end

endmodule

// File: rtl/can_flt_cmp.sv
module can_flt_cmp
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 64
) (
    input  obj_cfg_t [NUM_OBJ-1:0] objs,
    input  frame_t                 frame,
    output logic [NUM_OBJ-1:0]     match_vec
);

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
        always_comb match_vec[g] = obj_accepts(objs[g], frame);
    end

endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
    parameter int NUM_OBJ = 64,
    localparam int NUM_W  = $clog2(NUM_OBJ + 1)
) (
    input  logic [NUM_OBJ-1:0] req,
    output logic               found,
    output logic [NUM_W-1:0]   num
);

    always_comb begin
        num = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (req[i])
                num = NUM_W'(i + 1);
        end
        found = |req;
    end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_flt_pkg::*;
#(
    parameter int NUM_OBJ = 64,
    localparam int SEL_W  = $clog2(NUM_OBJ),
    localparam int NUM_W  = $clog2(NUM_OBJ + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [28:0]      cfg_id,
    input  logic [28:0]      cfg_mask,
    input  logic             cfg_xtd,
    input  logic             cfg_dir,
    input  logic             cfg_use_mask,
    input  logic             cfg_mask_xtd,
    input  logic             cfg_mask_dir,
    input  logic             cfg_valid,
    input  logic             frm_vld,
    input  logic [28:0]      frm_id,
    input  logic             frm_xtd,
    input  logic             frm_dir,
    output logic             res_vld,
    output logic             hit,
    output logic [NUM_W-1:0] hit_num
);

    obj_cfg_t                 wdata;
    obj_cfg_t [NUM_OBJ-1:0]   objs;
    frame_t                   frame;
    logic [NUM_OBJ-1:0]       match_vec;
    logic                     any_match;
    logic [NUM_W-1:0]         first_num;

    always_comb begin
        wdata.id       = cfg_id;
        wdata.mask     = cfg_mask;
        wdata.xtd      = cfg_xtd;
        wdata.dir      = cfg_dir;
        wdata.use_mask = cfg_use_mask;
        wdata.mask_xtd = cfg_mask_xtd;
        wdata.mask_dir = cfg_mask_dir;
        wdata.valid    = cfg_valid;
        frame.id       = frm_id;
        frame.xtd      = frm_xtd;
        frame.dir      = frm_dir;
    end

    can_flt_obj_store #(.NUM_OBJ(NUM_OBJ)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (wdata),
        .objs  (objs)
    );

    can_flt_cmp #(.NUM_OBJ(NUM_OBJ)) u_cmp (
        .objs      (objs),
        .frame     (frame),
        .match_vec (match_vec)
    );

    can_flt_prio #(.NUM_OBJ(NUM_OBJ)) u_prio (
        .req   (match_vec),
        .found (any_match),
        .num   (first_num)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            hit     <= 1'b0;
            hit_num <= '0;
        end else begin
            res_vld <= frm_vld;
            if (frm_vld) begin
                hit     <= any_match;
                hit_num <= first_num;
            end
        end
    end

    // Support logic for the checks below.
    logic [NUM_OBJ-1:0] valid_vec;
    logic [NUM_OBJ-1:0] valid_prev;
    logic [NUM_OBJ-1:0] below_hit;

    always_comb begin
        for (int i = 0; i < NUM_OBJ; i++) begin
            valid_vec[i] = objs[i].valid;
            below_hit[i] = (NUM_W'(i + 1) < hit_num);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            valid_prev <= '0;
        else
            valid_prev <= valid_vec;
    end

    p_result_follows_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> (res_vld && (hit == $past(|match_vec))));

    p_hold_without_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !frm_vld |=> (!res_vld && $stable(hit) && $stable(hit_num)));

    p_num_range_r9: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_num >= NUM_W'(1) && hit_num <= NUM_W'(NUM_OBJ)));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_num == '0));

    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (res_vld && hit) |-> (($past(match_vec) & below_hit) == '0));

    p_valid_only_r3: assert property (@(posedge clk) disable iff (rst)
        (res_vld && hit) |-> (valid_prev[hit_num - NUM_W'(1)] == 1'b1));

endmodule

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;

    localparam int NUM = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [28:0] cfg_id = '0;
    logic [28:0] cfg_mask = '0;
    logic        cfg_xtd = 1'b0, cfg_dir = 1'b0, cfg_use_mask = 1'b0;
    logic        cfg_mask_xtd = 1'b0, cfg_mask_dir = 1'b0, cfg_valid = 1'b0;
    logic        frm_vld = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_xtd = 1'b0, frm_dir = 1'b0;
    logic        res_vld, hit;
    logic [6:0]  hit_num;

    always #5 clk = ~clk;

    can_accept_filter uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cfg_xtd(cfg_xtd),
        .cfg_dir(cfg_dir), .cfg_use_mask(cfg_use_mask),
        .cfg_mask_xtd(cfg_mask_xtd), .cfg_mask_dir(cfg_mask_dir),
        .cfg_valid(cfg_valid), .frm_vld(frm_vld), .frm_id(frm_id),
        .frm_xtd(frm_xtd), .frm_dir(frm_dir), .res_vld(res_vld),
        .hit(hit), .hit_num(hit_num)
    );

    // Behavioural reference model
    logic [28:0] m_id   [NUM];
    logic [28:0] m_mask [NUM];
    logic        m_xtd [NUM], m_dir [NUM], m_um [NUM];
    logic        m_mx [NUM], m_md [NUM], m_v [NUM];
    logic        exp_vld = 1'b0, exp_hit = 1'b0;
    integer      exp_num = 0;
    integer      winner;
    integer      checks = 0, errors = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    function automatic bit ref_match(int k);
        logic [28:0] fid;
        if (!m_v[k]) return 1'b0;
        fid = frm_xtd ? frm_id : ((frm_id & 29'h7FF) << 18);
        for (int b = 0; b < 29; b++) begin
            if ((!m_um[k] || m_mask[k][b]) && (fid[b] != m_id[k][b]))
                return 1'b0;
        end
        if ((!m_um[k] || m_mx[k]) && (frm_xtd != m_xtd[k])) return 1'b0;
        if ((!m_um[k] || m_md[k]) && (frm_dir != m_dir[k])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_vld <= 1'b0; exp_hit <= 1'b0; exp_num <= 0;
            for (int i = 0; i < NUM; i++) m_v[i] <= 1'b0;
            for (int i = 0; i < NUM; i++) begin
                m_id[i] <= '0; m_mask[i] <= '0; m_xtd[i] <= 1'b0;
                m_dir[i] <= 1'b0; m_um[i] <= 1'b0; m_mx[i] <= 1'b0; m_md[i] <= 1'b0;
            end
        end else begin
            exp_vld <= frm_vld;
            if (frm_vld) begin
                winner = 0;
                for (int i = 0; i < NUM; i++)
                    if (winner == 0 && ref_match(i)) winner = i + 1;
                exp_hit <= (winner != 0);
                exp_num <= winner;
            end
            if (cfg_we) begin
                m_id[cfg_sel] <= cfg_id;   m_mask[cfg_sel] <= cfg_mask;
                m_xtd[cfg_sel] <= cfg_xtd; m_dir[cfg_sel] <= cfg_dir;
                m_um[cfg_sel] <= cfg_use_mask; m_mx[cfg_sel] <= cfg_mask_xtd;
                m_md[cfg_sel] <= cfg_mask_dir; m_v[cfg_sel] <= cfg_valid;
            end
        end
    end

    // Compare every cycle, after the edge has settled
    always @(posedge clk) begin
        #2;
        if (!done) begin
            checks++;
            if (res_vld !== exp_vld || hit !== exp_hit || hit_num !== 7'(exp_num)) begin
                errors++;
                $display("FAIL %s: got vld=%0b hit=%0b num=%0d, expected vld=%0b hit=%0b num=%0d",
                         cur_req, res_vld, hit, hit_num, exp_vld, exp_hit, exp_num);
            end
        end
    end

    task automatic set_obj(int num, logic [28:0] id, logic [28:0] mask, logic xtd,
                           logic dir, logic um, logic mx, logic md, logic v);
        cfg_sel = 6'(num - 1); cfg_id = id; cfg_mask = mask; cfg_xtd = xtd;
        cfg_dir = dir; cfg_use_mask = um; cfg_mask_xtd = mx; cfg_mask_dir = md;
        cfg_valid = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int n = 1; n <= NUM; n++) set_obj(n, '0, '0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic send(logic [28:0] id, logic xtd, logic dir);
        frm_id = id; frm_xtd = xtd; frm_dir = dir; frm_vld = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [28:0] STD123 = 29'h123 << 18;

    initial begin
        // R1: reset state and empty table
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        send(29'h0, 1'b0, 1'b0);
        send(29'h1ABCDEF0, 1'b1, 1'b1);

        // R4: exact compare when mask use is off (mask fields all zero)
        cur_req = "R4";
        set_obj(5, 29'h0ABC_1234, '0, 1, 0, 0, 0, 0, 1);
        send(29'h0ABC_1234, 1'b1, 1'b0);
        send(29'h0ABC_1235, 1'b1, 1'b0);
        send(29'h0ABC_1234, 1'b1, 1'b1);
        send(29'h0ABC_1234, 1'b0, 1'b0);

        // R5: per-bit mask, low byte don't-care
        cur_req = "R5";
        clear_all();
        set_obj(10, 29'h1555_5500, 29'h1FFF_FF00, 1, 0, 1, 1, 1, 1);
        send(29'h1555_55FF, 1'b1, 1'b0);
        send(29'h1555_5400, 1'b1, 1'b0);

        // R6: IDE flag masked in/out
        cur_req = "R6";
        clear_all();
        set_obj(7, STD123, 29'h1FFF_FFFF, 1, 0, 1, 0, 1, 1);
        send(29'h123, 1'b0, 1'b0);
        set_obj(7, STD123, 29'h1FFF_FFFF, 1, 0, 1, 1, 1, 1);
        send(29'h123, 1'b0, 1'b0);
        send(STD123, 1'b1, 1'b0);

        // R7: direction masked in/out
        cur_req = "R7";
        set_obj(7, STD123, 29'h1FFF_FFFF, 0, 1, 1, 1, 0, 1);
        send(29'h123, 1'b0, 1'b0);
        set_obj(7, STD123, 29'h1FFF_FFFF, 0, 1, 1, 1, 1, 1);
        send(29'h123, 1'b0, 1'b0);
        send(29'h123, 1'b0, 1'b1);

        // R8: standard alignment, upper frame bits ignored
        cur_req = "R8";
        clear_all();
        set_obj(20, 29'h2A5 << 18, '0, 0, 0, 0, 0, 0, 1);
        send({18'h3FFFF, 11'h2A5}, 1'b0, 1'b0);
        send(29'h2A5, 1'b1, 1'b0);
        set_obj(21, (29'h2A5 << 18) | 29'h1, '0, 0, 0, 0, 0, 0, 1);
        send(29'h2A5, 1'b0, 1'b0);

        // R3: invalid objects never accept
        cur_req = "R3";
        clear_all();
        set_obj(2, 29'h77, '0, 1, 0, 0, 0, 0, 0);
        send(29'h77, 1'b1, 1'b0);
        set_obj(40, 29'h77, '0, 1, 0, 0, 0, 0, 1);
        send(29'h77, 1'b1, 1'b0);

        // R9: lowest number wins, top object, full miss
        cur_req = "R9";
        set_obj(33, 29'h0, 29'h0, 0, 0, 1, 0, 0, 1);
        send(29'h77, 1'b1, 1'b0);
        set_obj(1, 29'h77, '0, 1, 0, 0, 0, 0, 1);
        send(29'h77, 1'b1, 1'b0);
        clear_all();
        set_obj(64, 29'h1FFF_FFFF, '0, 1, 1, 0, 0, 0, 1);
        send(29'h1FFF_FFFF, 1'b1, 1'b1);
        send(29'h1FFF_FFFE, 1'b1, 1'b1);

        // R10: write and strobe in the same cycle
        cur_req = "R10";
        set_obj(3, 29'h55, '0, 1, 0, 0, 0, 0, 1);
        cfg_sel = 6'd2; cfg_id = 29'h55; cfg_mask = '0; cfg_xtd = 1'b1;
        cfg_dir = 1'b0; cfg_use_mask = 1'b0; cfg_mask_xtd = 1'b0;
        cfg_mask_dir = 1'b0; cfg_valid = 1'b0; cfg_we = 1'b1;
        frm_id = 29'h55; frm_xtd = 1'b1; frm_dir = 1'b0; frm_vld = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; frm_vld = 1'b0;
        @(negedge clk);
        send(29'h55, 1'b1, 1'b0);

        // R2: holding behaviour over idle cycles
        cur_req = "R2";
        send(29'h1FFF_FFFF, 1'b1, 1'b1);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL %s: watchdog expired, got running, expected finished", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule